// File: doc/BRIEF.md
# Serial Link Control and Status Register Block

This block is the software-facing register slave of a serial link controller. It sits on a 32-bit APB-style bus and holds six word registers. These cover link control, link status, the transmit clock scaler, time codes, and the base addresses of the receive and transmit descriptor tables. It turns the control word into level and pulse outputs that steer the link and DMA logic, and it records link events in sticky flags. It folds the enabled flags into one interrupt line.

The link state machine and the DMA engines are outside this block. They appear only as event inputs (error pulses, received tick with its time value, descriptor-done pulses, the live two-bit link state) and as command outputs (a one-cycle core reset, a one-cycle time-code send with its value, the link mode levels and the DMA enables). The descriptor table holds 2^DESC_LOG2 eight-byte entries and is aligned to its own size. The base registers therefore keep no address bits below that alignment. The control word reports DESC_LOG2 in a read-only field so that software can size its tables.

Top module: `serlink_csr`

## Requirements
- R1: After reset the control word reads DESC_LOG2<<24, the scaler reads and drives DEFAULT_SCALER, the status word reads only the live link state, the base registers read 0, and irq is low.
- R2: The control word at offset 0x00 has writable bits 2 (start), 3 (autostart), 4 (disable), 6 (receive DMA enable), 7 (transmit DMA enable), 9, 10, 11 and 12 (interrupt enables); mask 0x00001EDC. Bits 31:24 always read DESC_LOG2 and ignore writes. Each writable link and DMA bit drives its own output.
- R3: Writing 1 to control bit 0 drives core_reset high for exactly one cycle, and bit 0 always reads back 0.
- R4: Status (offset 0x04) bits 1:0 show link_state live, with 3 meaning running. Any change of link_state sets the sticky change flag at status bit 9.
- R5: A pulse on err_evt[0..3] (disconnect, parity, escape, credit) sets status bit 2..5 respectively, and a pulse on bus_err sets bit 8; the flags stay set until cleared.
- R6: Writing status with a 1 in any of bits 2-5 or 8-12 clears that flag, and a 0 leaves it. If a source event falls in the same cycle as the clearing write, the flag stays set.
- R7: A pulse on rx_tick stores rx_time and sets status bit 10. The time-code register (offset 0x0C) reads the last received value in bits 7:0 and the last written transmit value in bits 15:8.
- R8: A write to offset 0x0C stores bits 15:8 as tc_value. If bit 16 is set, tc_send pulses for exactly one cycle. Without bit 16 there is no pulse, and bit 16 always reads 0.
- R9: The scaler register (offset 0x08) keeps the low SCALER_W bits of a write, reads them zero-extended and drives them on scaler.
- R10: The receive (0x10) and transmit (0x14) base registers keep bits 31:DESC_LOG2+3, read the lower bits as 0 and drive rx_base and tx_base.
- R11: rxdesc_done sets status bit 11 and txdesc_done sets bit 12. irq is high exactly when some flag among bits 9-12 is set and the control enable bit of the same number is set.
- R12: Reads of any other address, or of an address with bits 1:0 nonzero, return 0, and writes there change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | Write when high, read when low |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data for paddr |
| link_state | input | 2 | Current link state, 3 = running |
| err_evt | input | 4 | Error pulses: disconnect, parity, escape, credit |
| bus_err | input | 1 | Bus error pulse from the DMA side |
| rx_tick | input | 1 | Time code received pulse |
| rx_time | input | 8 | Received time code, valid with rx_tick |
| rxdesc_done | input | 1 | Receive descriptor finished pulse |
| txdesc_done | input | 1 | Transmit descriptor finished pulse |
| core_reset | output | 1 | One-cycle reset command to the link core |
| link_start | output | 1 | Link start request |
| link_autostart | output | 1 | Start on incoming activity |
| link_disable | output | 1 | Hold link down |
| rxdma_en | output | 1 | Receive DMA enable |
| txdma_en | output | 1 | Transmit DMA enable |
| scaler | output | SCALER_W | Transmit clock divider setting |
| rx_base | output | 32 | Receive descriptor table base |
| tx_base | output | 32 | Transmit descriptor table base |
| tc_send | output | 1 | One-cycle time-code send request |
| tc_value | output | 8 | Time code to send |
| irq | output | 1 | Interrupt request level |

## Verification
A received tick and a software write that clears the tick flag can land on the same clock edge, and the flag must survive that edge. The bench raises rx_tick during the access phase of a status write that has bit 10 set. It then reads status and the time-code register and expects bit 10 still set and the new time value captured. A plain clear afterwards must drop the flag and the interrupt.

// File: rtl/serlink_csr_pkg.sv
package serlink_csr_pkg;

   // Byte offsets of the word registers
   localparam int OFF_CTRL   = 'h00;
   localparam int OFF_STAT   = 'h04;
   localparam int OFF_SCALE  = 'h08;
   localparam int OFF_TCODE  = 'h0C;
   localparam int OFF_RXBASE = 'h10;
   localparam int OFF_TXBASE = 'h14;

   // Control word bit positions
   localparam int CB_RESET   = 0;
   localparam int CB_START   = 2;
   localparam int CB_AUTO    = 3;
   localparam int CB_DISABLE = 4;
   localparam int CB_RXDMA   = 6;
   localparam int CB_TXDMA   = 7;
   localparam int CB_IE_LO   = 9;   // enables 9..12 line up with flags 9..12
   localparam int CB_CFG_LSB = 24;

   localparam logic [31:0] CTRL_RW_MASK = 32'h0000_1EDC;

   // Sticky flag bank: index -> status bit position
   localparam int NFLAG = 9;
   localparam int STAT_POS [NFLAG] = '{2, 3, 4, 5, 8, 9, 10, 11, 12};
   localparam int FI_CHG   = 5;
   localparam int FI_TICK  = 6;
   localparam int FI_RXD   = 7;
   localparam int FI_TXD   = 8;
   localparam int NIRQ     = 4;   // flags FI_CHG..FI_TXD can interrupt

   localparam int TC_SEND_BIT = 16;

endpackage

// File: rtl/serlink_sticky.sv
module serlink_sticky #(
   parameter int W = 9
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set,
   input  logic [W-1:0] clr,
   output logic [W-1:0] flags
);

   generate
      if (W < 1) begin : g_bad_w
         $error("serlink_sticky: W must be at least 1");
      end
   endgenerate

   for (genvar i = 0; i < W; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            flags[i] <= 1'b0;
         else if (set[i])
            flags[i] <= 1'b1;        // event beats a clearing write
         else if (clr[i])
            flags[i] <= 1'b0;
      end

      // R5, R6: an event always leaves the flag set
      a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
         set[i] |=> flags[i]);

      // R6: a clear with no competing event drops the flag
      a_r6_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
         (clr[i] && !set[i]) |=> !flags[i]);
   end

endmodule

// File: rtl/serlink_tcode.sv
module serlink_tcode #(
   parameter int TC_W = 8
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr,
   input  logic [TC_W-1:0] wr_val,
   input  logic            wr_send,
   input  logic            rx_tick,
   input  logic [TC_W-1:0] rx_time,
   output logic [TC_W-1:0] tx_val,
   output logic            tx_send,
   output logic [TC_W-1:0] rx_val
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_val  <= '0;
         tx_send <= 1'b0;
         rx_val  <= '0;
      end else begin
         tx_send <= wr & wr_send;
         if (wr)
            tx_val <= wr_val;
         if (rx_tick)
            rx_val <= rx_time;
      end
   end

   // R7: the received value is held from the tick onward
   a_r7_capture: assert property (@(posedge clk) disable iff (!rst_n)
      rx_tick |=> (rx_val == $past(rx_time)));

   // R8: the send request carries the value written with it
   a_r8_send_value: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && wr_send) |=> (tx_send && tx_val == $past(wr_val)));

endmodule

// File: rtl/serlink_csr.sv
module serlink_csr
   import serlink_csr_pkg::*;
#(
   parameter int                  ADDR_W         = 5,
   parameter int                  DESC_LOG2      = 7,
   parameter int                  SCALER_W       = 8,
   parameter logic [SCALER_W-1:0] DEFAULT_SCALER = 4
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                psel,
   input  logic                penable,
   input  logic                pwrite,
   input  logic [ADDR_W-1:0]   paddr,
   input  logic [31:0]         pwdata,
   output logic [31:0]         prdata,
   input  logic [1:0]          link_state,
   input  logic [3:0]          err_evt,
   input  logic                bus_err,
   input  logic                rx_tick,
   input  logic [7:0]          rx_time,
   input  logic                rxdesc_done,
   input  logic                txdesc_done,
   output logic                core_reset,
   output logic                link_start,
   output logic                link_autostart,
   output logic                link_disable,
   output logic                rxdma_en,
   output logic                txdma_en,
   output logic [SCALER_W-1:0] scaler,
   output logic [31:0]         rx_base,
   output logic [31:0]         tx_base,
   output logic                tc_send,
   output logic [7:0]          tc_value,
   output logic                irq
);

   localparam int          BASE_LSB  = DESC_LOG2 + 3;
   localparam logic [31:0] CFG_FIELD = 32'(DESC_LOG2) << CB_CFG_LSB;

   generate
      if (DESC_LOG2 < 4 || DESC_LOG2 > 14) begin : g_bad_desc
         $error("serlink_csr: DESC_LOG2 must be within 4..14");
      end
      if (SCALER_W < 1 || SCALER_W > 32) begin : g_bad_scaler
         $error("serlink_csr: SCALER_W must be within 1..32");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("serlink_csr: ADDR_W must cover offsets up to 0x14");
      end
   endgenerate

   // ---------------- decode ----------------
   logic wr_en;
   logic hit_ctrl, hit_stat, hit_scale, hit_tcode, hit_rxb, hit_txb;

   assign wr_en     = psel & penable & pwrite;
   assign hit_ctrl  = (paddr == ADDR_W'(OFF_CTRL));
   assign hit_stat  = (paddr == ADDR_W'(OFF_STAT));
   assign hit_scale = (paddr == ADDR_W'(OFF_SCALE));
   assign hit_tcode = (paddr == ADDR_W'(OFF_TCODE));
   assign hit_rxb   = (paddr == ADDR_W'(OFF_RXBASE));
   assign hit_txb   = (paddr == ADDR_W'(OFF_TXBASE));

   // ---------------- control word and plain registers ----------------
   logic [31:0]          ctrl_q;
   logic                 core_reset_q;
   logic [SCALER_W-1:0]  scaler_q;
   logic [31:BASE_LSB]   rxb_q, txb_q;
   logic [1:0]           link_prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q       <= '0;
         core_reset_q <= 1'b0;
         scaler_q     <= DEFAULT_SCALER;
         rxb_q        <= '0;
         txb_q        <= '0;
         link_prev_q  <= '0;
      end else begin
         core_reset_q <= wr_en & hit_ctrl & pwdata[CB_RESET];
         link_prev_q  <= link_state;
         if (wr_en && hit_ctrl)
            ctrl_q <= pwdata & CTRL_RW_MASK;
         if (wr_en && hit_scale)
            scaler_q <= pwdata[SCALER_W-1:0];
         if (wr_en && hit_rxb)
            rxb_q <= pwdata[31:BASE_LSB];
         if (wr_en && hit_txb)
            txb_q <= pwdata[31:BASE_LSB];
      end
   end

   assign core_reset     = core_reset_q;
   assign link_start     = ctrl_q[CB_START];
   assign link_autostart = ctrl_q[CB_AUTO];
   assign link_disable   = ctrl_q[CB_DISABLE];
   assign rxdma_en       = ctrl_q[CB_RXDMA];
   assign txdma_en       = ctrl_q[CB_TXDMA];
   assign scaler         = scaler_q;
   assign rx_base        = {rxb_q, {BASE_LSB{1'b0}}};
   assign tx_base        = {txb_q, {BASE_LSB{1'b0}}};

   // ---------------- sticky status flags ----------------
   logic             link_chg;
   logic [NFLAG-1:0] flag_set, flag_clr, flags;

   assign link_chg = (link_state != link_prev_q);
   assign flag_set = {txdesc_done, rxdesc_done, rx_tick, link_chg, bus_err, err_evt};

   always_comb begin
      for (int i = 0; i < NFLAG; i++)
         flag_clr[i] = wr_en & hit_stat & pwdata[STAT_POS[i]];
   end

   serlink_sticky #(.W(NFLAG)) u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (flag_set),
      .clr   (flag_clr),
      .flags (flags)
   );

   // ---------------- time codes ----------------
   logic [7:0] tc_rx;

   serlink_tcode #(.TC_W(8)) u_tcode (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (wr_en & hit_tcode),
      .wr_val  (pwdata[15:8]),
      .wr_send (pwdata[TC_SEND_BIT]),
      .rx_tick (rx_tick),
      .rx_time (rx_time),
      .tx_val  (tc_value),
      .tx_send (tc_send),
      .rx_val  (tc_rx)
   );

   // ---------------- interrupt ----------------
   logic [NIRQ-1:0] irq_en, irq_pend;

   assign irq_en   = ctrl_q[CB_IE_LO +: NIRQ];
   assign irq_pend = flags[FI_CHG +: NIRQ];
   assign irq      = |(irq_en & irq_pend);

   // ---------------- read mux ----------------
   logic [31:0] stat_rd, scale_rd;

   always_comb begin
      stat_rd       = '0;
      stat_rd[1:0]  = link_state;
      for (int i = 0; i < NFLAG; i++)
         stat_rd[STAT_POS[i]] = flags[i];
      scale_rd                 = '0;
      scale_rd[SCALER_W-1:0]   = scaler_q;
   end

   always_comb begin
      prdata = '0;
      if (hit_ctrl)  prdata = ctrl_q | CFG_FIELD;
      if (hit_stat)  prdata = stat_rd;
      if (hit_scale) prdata = scale_rd;
      if (hit_tcode) prdata = {16'h0, tc_value, tc_rx};
      if (hit_rxb)   prdata = rx_base;
      if (hit_txb)   prdata = tx_base;
   end

   // R4: a link state change is recorded in the change flag
   a_r4_change_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (link_state != $past(link_state)) |=> flags[FI_CHG]);

   // R3: a reset command is only issued by a control write with bit 0
   a_r3_reset_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(core_reset) |-> $past(wr_en && hit_ctrl && pwdata[CB_RESET]));

   // R11: the interrupt line never rises while every enable is off
   a_r11_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en == '0) |-> !irq);

endmodule

// File: tb/serlink_csr_test.sv
`timescale 1ns/1ps
module serlink_csr_test;

   localparam int ADDR_W    = 5;
   localparam int DESC_LOG2 = 7;
   localparam int SCALER_W  = 8;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              psel, penable, pwrite;
   logic [ADDR_W-1:0] paddr;
   logic [31:0]       pwdata, prdata;
   logic [1:0]        link_state;
   logic [3:0]        err_evt;
   logic              bus_err, rx_tick, rxdesc_done, txdesc_done;
   logic [7:0]        rx_time;
   logic              core_reset, link_start, link_autostart, link_disable;
   logic              rxdma_en, txdma_en, tc_send, irq;
   logic [SCALER_W-1:0] scaler;
   logic [31:0]       rx_base, tx_base;
   logic [7:0]        tc_value;

   serlink_csr #(.ADDR_W(ADDR_W), .DESC_LOG2(DESC_LOG2), .SCALER_W(SCALER_W),
                 .DEFAULT_SCALER(8'd4)) uut (
      .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .link_state(link_state),
      .err_evt(err_evt), .bus_err(bus_err), .rx_tick(rx_tick), .rx_time(rx_time),
      .rxdesc_done(rxdesc_done), .txdesc_done(txdesc_done), .core_reset(core_reset),
      .link_start(link_start), .link_autostart(link_autostart),
      .link_disable(link_disable), .rxdma_en(rxdma_en), .txdma_en(txdma_en),
      .scaler(scaler), .rx_base(rx_base), .tx_base(tx_base), .tc_send(tc_send),
      .tc_value(tc_value), .irq(irq));

   always #5 clk = ~clk;

   int n_run  = 0;
   int n_fail = 0;
   int rst_cnt = 0;
   int tc_cnt  = 0;
   bit done = 0;

   always @(posedge clk) begin
      if (core_reset) rst_cnt++;
      if (tc_send)    tc_cnt++;
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   task automatic apb_wr(input logic [ADDR_W-1:0] a, input logic [31:0] d, input bit coll);
      @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d;
      @(negedge clk); penable = 1; if (coll) rx_tick = 1;
      @(negedge clk); psel = 0; penable = 0; pwrite = 0; rx_tick = 0;
      #1;
   endtask

   task automatic apb_rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
      @(negedge clk); psel = 1; pwrite = 0; paddr = a;
      @(negedge clk); penable = 1; #1 d = prdata;
      @(negedge clk); psel = 0; penable = 0;
   endtask

   task automatic pulse(input int which);
      @(negedge clk);
      case (which)
         0, 1, 2, 3: err_evt[which] = 1;
         4: bus_err = 1;
         5: rx_tick = 1;
         6: rxdesc_done = 1;
         default: txdesc_done = 1;
      endcase
      @(negedge clk);
      err_evt = 0; bus_err = 0; rx_tick = 0; rxdesc_done = 0; txdesc_done = 0;
      #1;
   endtask

   function automatic string vtag(input logic [31:0] a);
      case (a)
         32'h00: return "R2";
         32'h08: return "R9";
         32'h0C: return "R8";
         32'h10, 32'h14: return "R10";
         default: return "R12";
      endcase
   endfunction

   // {address, write data, expected readback}
   localparam logic [95:0] VEC [8] = '{
      {32'h00, 32'hFFFF_FFFF, 32'h0700_1EDC},
      {32'h00, 32'h0000_0A44, 32'h0700_0A44},
      {32'h08, 32'h0001_2345, 32'h0000_0045},
      {32'h10, 32'hDEAD_BEEF, 32'hDEAD_BC00},
      {32'h14, 32'h0000_07FF, 32'h0000_0400},
      {32'h0C, 32'h0000_A500, 32'h0000_A500},
      {32'h18, 32'hFFFF_FFFF, 32'h0000_0000},
      {32'h00, 32'h0000_0000, 32'h0700_0000}
   };

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 1, 0);
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] rd;
      int c0;
      rst_n = 0; psel = 0; penable = 0; pwrite = 0; paddr = '0; pwdata = '0;
      link_state = 0; err_evt = 0; bus_err = 0; rx_tick = 0; rx_time = 0;
      rxdesc_done = 0; txdesc_done = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R1: reset state
      apb_rd(5'h00, rd); check("R1 ctrl", rd, 32'h0700_0000);
      apb_rd(5'h04, rd); check("R1 status", rd, 32'h0);
      apb_rd(5'h08, rd); check("R1 scaler", rd, 32'h4);
      apb_rd(5'h10, rd); check("R1 rx base", rd, 32'h0);
      check("R1 irq", {31'h0, irq}, 32'h0);

      // Vector walk: write, then read back
      for (int i = 0; i < 8; i++) begin
         apb_wr(ADDR_W'(VEC[i][95:64]), VEC[i][63:32], 1'b0);
         apb_rd(ADDR_W'(VEC[i][95:64]), rd);
         check(vtag(VEC[i][95:64]), rd, VEC[i][31:0]);
      end
      check("R9 scaler port", {24'h0, scaler}, 32'h45);
      check("R10 rx_base port", rx_base, 32'hDEAD_BC00);
      check("R10 tx_base port", tx_base, 32'h0000_0400);
      apb_rd(5'h09, rd); check("R12 unaligned", rd, 32'h0);

      // R2: link and DMA control outputs
      apb_wr(5'h00, 32'h0000_00DC, 1'b0);
      check("R2 outputs", {27'h0, link_start, link_autostart, link_disable, rxdma_en, txdma_en},
            32'h1F);
      apb_wr(5'h00, 32'h0, 1'b0);

      // R3: reset command pulse
      c0 = rst_cnt;
      apb_wr(5'h00, 32'h1, 1'b0);
      @(negedge clk);
      check("R3 pulse width", 32'(rst_cnt - c0), 32'd1);
      apb_rd(5'h00, rd); check("R3 bit0 reads 0", rd, 32'h0700_0000);

      // R8: time-code send
      c0 = tc_cnt;
      apb_wr(5'h0C, 32'h0001_7700, 1'b0);
      @(negedge clk);
      check("R8 send pulse", 32'(tc_cnt - c0), 32'd1);
      check("R8 tc_value", {24'h0, tc_value}, 32'h77);
      apb_rd(5'h0C, rd); check("R8 bit16 reads 0", rd, 32'h0000_7700);
      c0 = tc_cnt;
      apb_wr(5'h0C, 32'h0000_7700, 1'b0);
      @(negedge clk);
      check("R8 no send without bit16", 32'(tc_cnt - c0), 32'd0);

      // R4: link running, change flag, interrupt
      @(negedge clk); link_state = 3;
      @(negedge clk);
      apb_rd(5'h04, rd); check("R4 up and changed", rd, 32'h0000_0203);
      apb_wr(5'h00, 32'h0000_0200, 1'b0);
      check("R11 change irq", {31'h0, irq}, 32'h1);
      apb_wr(5'h04, 32'h0000_0200, 1'b0);
      check("R6 change cleared irq", {31'h0, irq}, 32'h0);
      apb_rd(5'h04, rd); check("R6 change cleared", rd, 32'h3);

      // R5: errors are sticky, R6: zero writes are ignored
      pulse(2);
      apb_rd(5'h04, rd); check("R5 escape flag", rd, 32'h13);
      apb_wr(5'h04, 32'h0, 1'b0);
      apb_rd(5'h04, rd); check("R6 zero write keeps", rd, 32'h13);
      apb_wr(5'h04, 32'h10, 1'b0);
      apb_rd(5'h04, rd); check("R6 escape cleared", rd, 32'h3);
      pulse(4);
      apb_rd(5'h04, rd); check("R5 bus error", rd, 32'h103);
      apb_wr(5'h04, 32'h13C, 1'b0);
      apb_rd(5'h04, rd); check("R6 bus error cleared", rd, 32'h3);

      // R7: tick capture
      rx_time = 8'h5A;
      pulse(5);
      apb_rd(5'h04, rd); check("R7 tick flag", rd, 32'h403);
      apb_rd(5'h0C, rd); check("R7 rx time", rd, 32'h0000_775A);
      apb_wr(5'h00, 32'h0000_0400, 1'b0);
      check("R11 tick irq", {31'h0, irq}, 32'h1);

      // R6: clearing write and new tick on the same edge
      rx_time = 8'h3C;
      apb_wr(5'h04, 32'h0000_0400, 1'b1);
      apb_rd(5'h04, rd); check("R6 event wins", rd, 32'h403);
      apb_rd(5'h0C, rd); check("R7 rx time on collision", rd, 32'h0000_773C);
      check("R11 irq held on collision", {31'h0, irq}, 32'h1);
      apb_wr(5'h04, 32'h0000_0400, 1'b0);
      apb_rd(5'h04, rd); check("R6 tick cleared", rd, 32'h3);
      check("R11 tick irq gone", {31'h0, irq}, 32'h0);

      // R11: descriptor flags with only receive enable on
      apb_wr(5'h00, 32'h0000_0800, 1'b0);
      pulse(7);
      check("R11 masked tx irq", {31'h0, irq}, 32'h0);
      apb_rd(5'h04, rd); check("R11 tx flag", rd, 32'h1003);
      pulse(6);
      check("R11 rx irq", {31'h0, irq}, 32'h1);
      apb_rd(5'h04, rd); check("R11 rx flag", rd, 32'h1803);
      apb_wr(5'h04, 32'h0000_1800, 1'b0);
      check("R11 irq cleared", {31'h0, irq}, 32'h0);

      // R4: link going down
      @(negedge clk); link_state = 0;
      @(negedge clk);
      apb_rd(5'h04, rd); check("R4 down and changed", rd, 32'h200);

      // R1: reset in the middle of operation
      @(negedge clk); rst_n = 0;
      @(negedge clk); rst_n = 1;
      #1;
      check("R1 scaler after reset", {24'h0, scaler}, 32'h4);
      check("R1 rx_base after reset", rx_base, 32'h0);
      apb_rd(5'h04, rd); check("R1 status after reset", rd, 32'h0);

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule